// File: doc/BRIEF.md
# TDM Slot Transmitter (Clock Slave)

This block puts 16-bit audio words onto a serial data line that several transmitters share in time-division fashion. An external master owns the bit clock and the frame sync. The block runs directly on that bit clock and recovers the frame position from the sync. It places one word in each time slot that its slot mask claims. For every other slot it holds its output enable low, so other devices can drive the line there. Slots are plain numbered positions with no left or right meaning. A frame has SLOTS slots of WORD_W bits each, so 8 x 16 = 128 bit periods by default.

Words enter through a ready/valid port and wait in a small FIFO. They leave in acceptance order, one per claimed slot. Two sync widths are supported: a sync high for one bit period, or high for one full word. If the FIFO is empty when a claimed slot begins, the slot is sent as zeros and a sticky underrun flag is raised. A one-cycle clear input drops the flag.

Timing convention: the sync level sampled at a rising edge describes the bit period that this edge closes. The data and enable launched at a rising edge describe the bit period that this edge opens. After lock, the block launches each bit from the position it predicts for the next period.

Top module: `tdm_slot_tx`

## Requirements
- R1: While reset is high, and at the first falling edge after reset, ser_oe = 0, ser_out = 0, underrun = 0 and s_ready = 1. The block is unlocked.
- R2: When the sampled sync is 1 and the previous sample was 0, the period just closed is frame position 0. The period just opened is position 1, and positions count up modulo SLOTS*WORD_W from there. Nothing is driven before the first such rise. Slot 0 of the frame in which lock is gained is not driven.
- R3: ser_oe is 1 for the whole of slot k (positions k*WORD_W .. k*WORD_W+WORD_W-1) exactly when bit k of slot_mask was 1 at that slot's first position. ser_out is 0 whenever ser_oe is 0.
- R4: Each driven slot carries one accepted word, most significant bit first, at bit position b of the slot. Words are taken in the order they were accepted.
- R5: fs_len_bit = 1 expects the sync high only at position 0. fs_len_bit = 0 expects it high at positions 0 .. WORD_W-1. While locked, a sampled sync level that differs from this expectation (other than a rise) drops lock. The line is released from the next period until a new rise.
- R6: If the FIFO is empty at the first position of a claimed slot, the slot is driven with ser_oe = 1 and all-zero data. underrun is set at that edge and stays 1.
- R7: underrun_clr = 1 at an edge clears underrun unless the same edge sets it again, in which case setting wins.
- R8: s_ready = 1 while the FIFO holds fewer than FIFO_DEPTH words. A word is accepted on an edge where s_valid and s_ready are both 1. A word popped and a word accepted on the same edge are both honoured.
- R9: A sync rise while locked at any position other than an expected position 0 realigns the count so that the next period is position 1. Any slot in progress is abandoned and the line is released until the next slot start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the external master |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync from the external master |
| fs_len_bit | input | 1 | Sync width: 1 = one bit period, 0 = one word |
| slot_mask | input | SLOTS | Bit k set: this block drives slot k |
| s_data | input | WORD_W | Sample word to queue |
| s_valid | input | 1 | s_data is valid |
| s_ready | output | 1 | FIFO can take a word |
| ser_out | output | 1 | Serial data, launched on the rising edge |
| ser_oe | output | 1 | Drive enable for ser_out |
| underrun | output | 1 | Sticky: a claimed slot began with no word queued |
| underrun_clr | input | 1 | One-cycle clear of underrun |

## Verification
Several masks are applied:
- all slots claimed, which shows back-to-back slot loads;
- an alternating pattern, which shows that released slots stay silent and that words are not consumed by unclaimed slots;
- a mask changed in the middle of a slot, which shows that the mask is sampled only at a slot's first bit.

The sync is exercised in several ways:
- in both width modes, which shows the expected high window;
- with a too-short word-mode sync, which must cost the lock;
- with an early sync, which must realign without a stray partial slot.

The source is stalled long enough to drain the FIFO, which separates zero-filled driven slots from released ones. A cycle-by-cycle model compares all four outputs throughout.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  typedef enum logic {
    SYNC_WORD = 1'b0,
    SYNC_BIT  = 1'b1
  } sync_len_e;

  function automatic bit is_pow2(input int v);
    return (v > 1) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/tdm_sample_fifo.sv
module tdm_sample_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] wr_data,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic         rd_pop,
  output logic [W-1:0] rd_data,
  output logic         empty
);

  localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          push, pop;

  assign wr_ready = (count != FULL_CNT);
  assign empty    = (count == '0);
  assign push     = wr_valid & wr_ready;
  assign pop      = rd_pop & ~empty;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/tdm_frame_tracker.sv
module tdm_frame_tracker
  import tdm_tx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SLOTS  = 8,
  parameter int POS_W  = $clog2(WORD_W * SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fsync,
  input  sync_len_e        len_mode,
  output logic             lock_q,
  output logic             lock_nxt,
  output logic [POS_W-1:0] pos_nxt,
  output logic             seq_break
);

  localparam logic [POS_W:0] WORD_LEN = (POS_W + 1)'(WORD_W);

  logic             fs_q;
  logic [POS_W-1:0] pos_q;
  logic             rise, exp_hi, width_err;

  always_comb begin
    rise      = fsync & ~fs_q;
    // Expected sync level for the period that the current edge closes.
    if (len_mode == SYNC_BIT) exp_hi = (pos_q == '0);
    else                      exp_hi = ({1'b0, pos_q} < WORD_LEN);
    width_err = lock_q & ~rise & (fsync != exp_hi);
    lock_nxt  = rise | (lock_q & ~width_err);
    seq_break = rise & ~(lock_q & (pos_q == '0));
    if (rise)        pos_nxt = POS_W'(1);
    else if (lock_q) pos_nxt = pos_q + 1'b1;
    else             pos_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_q   <= 1'b0;
      lock_q <= 1'b0;
      pos_q  <= '0;
    end else begin
      fs_q   <= fsync;
      lock_q <= lock_nxt;
      pos_q  <= pos_nxt;
    end
  end

endmodule

// File: rtl/tdm_slot_shifter.sv
module tdm_slot_shifter #(
  parameter int WORD_W = 16,
  parameter int SLOTS  = 8,
  parameter int POS_W  = $clog2(WORD_W * SLOTS),
  parameter int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_nxt,
  input  logic [POS_W-1:0]  pos_nxt,
  input  logic              seq_break,
  input  logic [SLOTS-1:0]  slot_mask,
  input  logic [WORD_W-1:0] head_data,
  input  logic              fifo_empty,
  input  logic              uf_clr,
  output logic              pop,
  output logic              ser_out,
  output logic              ser_oe,
  output logic              underrun
);

  logic [BIT_W-1:0]       bit_nxt;
  logic [POS_W-BIT_W-1:0] slot_nxt;
  logic                   act_q, act_nxt, mine, load, uf_set;
  logic [WORD_W-1:0]      shreg;

  assign bit_nxt  = pos_nxt[BIT_W-1:0];
  assign slot_nxt = pos_nxt[POS_W-1:BIT_W];

  always_comb begin
    mine = slot_mask[slot_nxt];
    if (!lock_nxt)            act_nxt = 1'b0;
    else if (bit_nxt == '0)   act_nxt = mine;
    else                      act_nxt = act_q & ~seq_break;
    load   = lock_nxt & (bit_nxt == '0) & mine;
    pop    = load & ~fifo_empty;
    uf_set = load & fifo_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q    <= 1'b0;
      ser_out  <= 1'b0;
      shreg    <= '0;
      underrun <= 1'b0;
    end else begin
      act_q    <= act_nxt;
      underrun <= uf_set | (underrun & ~uf_clr);
      if (load) begin
        if (fifo_empty) begin
          ser_out <= 1'b0;
          shreg   <= '0;
        end else begin
          ser_out <= head_data[WORD_W-1];
          shreg   <= {head_data[WORD_W-2:0], 1'b0};
        end
      end else if (act_nxt) begin
        ser_out <= shreg[WORD_W-1];
        shreg   <= {shreg[WORD_W-2:0], 1'b0};
      end else begin
        ser_out <= 1'b0;
      end
    end
  end

  assign ser_oe = act_q;

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_tx_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int SLOTS      = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic              fs_len_bit,
  input  logic [SLOTS-1:0]  slot_mask,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              ser_out,
  output logic              ser_oe,
  output logic              underrun,
  input  logic              underrun_clr
);

  localparam int POS_W = $clog2(WORD_W * SLOTS);

  if (!is_pow2(WORD_W) || !is_pow2(SLOTS) || !is_pow2(FIFO_DEPTH)) begin : g_bad_params
    $error("tdm_slot_tx: WORD_W, SLOTS and FIFO_DEPTH must be powers of two");
  end

  logic              trk_locked, lock_nxt, seq_break;
  logic [POS_W-1:0]  pos_nxt;
  logic [WORD_W-1:0] head_data;
  logic              fifo_empty, pop;

  tdm_sample_fifo #(
    .W     (WORD_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (s_data),
    .wr_valid (s_valid),
    .wr_ready (s_ready),
    .rd_pop   (pop),
    .rd_data  (head_data),
    .empty    (fifo_empty)
  );

  tdm_frame_tracker #(
    .WORD_W (WORD_W),
    .SLOTS  (SLOTS),
    .POS_W  (POS_W)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .fsync     (fsync),
    .len_mode  (sync_len_e'(fs_len_bit)),
    .lock_q    (trk_locked),
    .lock_nxt  (lock_nxt),
    .pos_nxt   (pos_nxt),
    .seq_break (seq_break)
  );

  tdm_slot_shifter #(
    .WORD_W (WORD_W),
    .SLOTS  (SLOTS),
    .POS_W  (POS_W)
  ) u_shift (
    .clk        (clk),
    .rst        (rst),
    .lock_nxt   (lock_nxt),
    .pos_nxt    (pos_nxt),
    .seq_break  (seq_break),
    .slot_mask  (slot_mask),
    .head_data  (head_data),
    .fifo_empty (fifo_empty),
    .uf_clr     (underrun_clr),
    .pop        (pop),
    .ser_out    (ser_out),
    .ser_oe     (ser_oe),
    .underrun   (underrun)
  );

endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk (
  input logic clk,
  input logic rst,
  input logic ser_out,
  input logic ser_oe,
  input logic underrun,
  input logic underrun_clr,
  input logic s_ready,
  input logic locked
);

  // R1: reset leaves the line released, flag clear, FIFO accepting
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!ser_oe && !ser_out && !underrun && s_ready));

  // R3: a released line carries zero
  a_r3_released_low: assert property (@(posedge clk) disable iff (rst)
    !ser_oe |-> !ser_out);

  // R2: no drive without frame lock
  a_r2_no_drive_unlocked: assert property (@(posedge clk) disable iff (rst)
    !locked |-> !ser_oe);

  // R6: underrun is sticky without a clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (underrun && !underrun_clr) |=> underrun);

  // R6: a new underrun coincides with a driven zero slot start
  a_r6_zero_fill: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> (ser_oe && !ser_out));

endmodule

bind tdm_slot_tx tdm_slot_tx_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .ser_out      (ser_out),
  .ser_oe       (ser_oe),
  .underrun     (underrun),
  .underrun_clr (underrun_clr),
  .s_ready      (s_ready),
  .locked       (trk_locked)
);

// File: tb/tdm_slot_tx_tb.sv
module tdm_slot_tx_tb;

  localparam int CLK_P = 10;
  localparam int WORD  = 16;
  localparam int SLOTS = 8;
  localparam int DEPTH = 4;
  localparam int FRAME = WORD * SLOTS;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             fsync = 1'b0;
  logic             fs_len_bit = 1'b1;
  logic [SLOTS-1:0] slot_mask = '0;
  logic [WORD-1:0]  s_data = '0;
  logic             s_valid = 1'b0;
  logic             s_ready, ser_out, ser_oe, underrun;
  logic             underrun_clr = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  tdm_slot_tx #(.WORD_W(WORD), .SLOTS(SLOTS), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .fsync        (fsync),
    .fs_len_bit   (fs_len_bit),
    .slot_mask    (slot_mask),
    .s_data       (s_data),
    .s_valid      (s_valid),
    .s_ready      (s_ready),
    .ser_out      (ser_out),
    .ser_oe       (ser_oe),
    .underrun     (underrun),
    .underrun_clr (underrun_clr)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string phase = "R1 reset";
  bit    feed_on = 1'b0;

  // Behavioural reference model
  logic [WORD-1:0] q[$];
  logic [WORD-1:0] m_word = '0;
  bit m_fs = 0, m_lock = 0, m_act = 0, m_out = 0, m_oe = 0, m_uf = 0;
  int m_pos = 0;
  int push_cnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_fs = 0; m_lock = 0; m_act = 0; m_out = 0; m_oe = 0; m_uf = 0;
      m_pos = 0;
      q.delete();
    end else begin
      bit rise, nlock, brk, nact, setuf, was_empty, rdy;
      int npos, slen, bitn, slotn;
      rise  = fsync && !m_fs;
      slen  = fs_len_bit ? 1 : WORD;
      nlock = m_lock;
      brk   = 0;
      npos  = 0;
      if (rise) begin
        brk   = !(m_lock && m_pos == 0);
        nlock = 1;
        npos  = 1;
      end else if (m_lock) begin
        if (fsync != (m_pos < slen)) nlock = 0;
        npos = (m_pos + 1) % FRAME;
      end
      bitn      = npos % WORD;
      slotn     = npos / WORD;
      was_empty = (q.size() == 0);
      rdy       = (q.size() < DEPTH);
      setuf     = 0;
      if (!nlock)         nact = 0;
      else if (bitn == 0) nact = slot_mask[slotn[2:0]];
      else                nact = m_act && !brk;
      m_out = 0;
      if (nact) begin
        if (bitn == 0) begin
          if (!was_empty) m_word = q.pop_front();
          else begin
            m_word = '0;
            setuf  = 1;
          end
        end
        m_out = m_word[WORD-1-bitn];
      end
      if (s_valid && rdy) begin
        q.push_back(s_data);
        push_cnt++;
      end
      m_uf   = setuf || (m_uf && !underrun_clr);
      m_oe   = nact;
      m_act  = nact;
      m_lock = nlock;
      m_pos  = npos;
      m_fs   = fsync;
    end
  end

  // Sample source: a new pattern word after each acceptance
  always @(negedge clk) begin
    s_valid <= feed_on;
    s_data  <= 16'(push_cnt * 40503 + 4660);
  end

  task automatic chk(input string tag, input string sig, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, sig, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(phase, "ser_oe (R3)",   32'(ser_oe),   32'(m_oe));
      chk(phase, "ser_out (R4)",  32'(ser_out),  32'(m_out));
      chk(phase, "underrun (R6)", 32'(underrun), 32'(m_uf));
      chk(phase, "s_ready (R8)",  32'(s_ready),  32'(q.size() < DEPTH));
    end
  end

  task automatic send_frame(input int len, input int hi);
    for (int p = 0; p < len; p++) begin
      @(negedge clk);
      fsync = (p < hi);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset values at the ports
    chk("R1 reset", "ser_oe",   32'(ser_oe),   32'd0);
    chk("R1 reset", "ser_out",  32'(ser_out),  32'd0);
    chk("R1 reset", "underrun", 32'(underrun), 32'd0);
    chk("R1 reset", "s_ready",  32'(s_ready),  32'd1);
    rst = 1'b0;

    phase = "R8 fill and backpressure";
    feed_on = 1'b1;
    repeat (12) @(negedge clk);

    phase = "R2 lock, all slots";
    slot_mask = 8'hFF;
    send_frame(FRAME, 1);
    send_frame(FRAME, 1);

    phase = "R3 R4 alternating mask";
    slot_mask = 8'hA5;
    send_frame(FRAME, 1);
    send_frame(FRAME, 1);

    phase = "R3 mask change mid-slot";
    fork
      send_frame(FRAME, 1);
      begin
        repeat (40) @(negedge clk);
        slot_mask = 8'h5A;
      end
    join

    phase = "R5 word-long sync";
    fs_len_bit = 1'b0;
    slot_mask  = 8'h3C;
    send_frame(FRAME, WORD);
    send_frame(FRAME, WORD);

    phase = "R5 short sync in word mode";
    send_frame(FRAME, 1);
    send_frame(FRAME, WORD);
    send_frame(FRAME, WORD);

    phase = "R6 underrun zero fill";
    feed_on   = 1'b0;
    slot_mask = 8'h81;
    send_frame(FRAME, WORD);
    send_frame(FRAME, WORD);

    phase = "R7 clear pulse";
    slot_mask = 8'h00;
    fork
      send_frame(FRAME, WORD);
      begin
        repeat (30) @(negedge clk);
        underrun_clr = 1'b1;
        @(negedge clk);
        underrun_clr = 1'b0;
      end
    join
    slot_mask = 8'h01;
    fork
      send_frame(FRAME, WORD);
      begin
        repeat (2) @(negedge clk);
        underrun_clr = 1'b1;
        @(negedge clk);
        underrun_clr = 1'b0;
      end
    join

    phase = "R9 early sync realign";
    feed_on    = 1'b1;
    fs_len_bit = 1'b1;
    slot_mask  = 8'hFF;
    send_frame(FRAME, 1);
    send_frame(70, 1);
    send_frame(FRAME, 1);
    send_frame(FRAME, 1);

    repeat (4) @(negedge clk);
    summary();
  end

endmodule